// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits next to one processor's load/store port and arbitrates the load-exclusive and store-exclusive pairs that software uses to build lock-free atomic operations. A load-exclusive opens a reservation. A later store-exclusive either lets its write through to memory and reports status 0, or blocks the write and reports status 1. The requester retries in software until it sees status 0.

The reservation is tracked in one of two ways, selected by the shared attribute of the load-exclusive. For shareable memory the monitor keeps an exact granule tag, and a write from another agent seen on the snoop port cancels it. For non-shareable memory it keeps only a "reservation pending" flag. Word and doubleword accesses are supported, and a doubleword is one reservation unit.

The decision is combinational, so status and write enable appear in the same cycle as the request. The monitor handles one request per cycle.

Top module: `excl_monitor`

## Requirements
- R1: After reset no reservation exists. A store-exclusive (op code 1) issued before any load-exclusive drives no write and returns status 1.
- R2: A load-exclusive (op code 0) with the shared bit set records the request's granule as reserved. It replaces any reservation held before, so a store-exclusive to the older granule fails.
- R3: A load-exclusive with the shared bit clear records only a pending flag. A following non-shared store-exclusive to any address succeeds.
- R4: A non-shared store-exclusive writes and returns status 0 when a reservation is pending. With nothing pending it drives no write and returns status 1.
- R5: A shared store-exclusive succeeds only when a shared reservation exists and its granule equals the request's. A granule is the address with its low log2(GRANULE_BYTES) bits ignored, 8 bytes by default. Otherwise the store drives no write and returns status 1.
- R6: Every store-exclusive removes the reservation, whether it succeeds or fails.
- R7: mem_we bit 0 enables the low 32-bit word and bit 1 enables the high word. A doubleword write drives 2'b11 and a word write drives 2'b01. A failed doubleword store-exclusive drives 2'b00, never a single lane.
- R8: A snoop write to the reserved granule cancels a shared reservation. A snoop to another granule has no effect. A snoop never cancels a non-shared reservation. A store-exclusive in the same cycle as a cancelling snoop fails.
- R9: A clear request (op code 3) drops any reservation. It drives no write and returns status 0.
- R10: A plain store (op code 2) always writes, with lanes chosen by size. It returns status 0 and leaves the reservation unchanged.
- R11: Outputs are combinational on the request. When req_valid is low, or when the request is a load-exclusive, mem_we is 0 and status is 0. When mem_we is nonzero, mem_wdata and mem_addr equal the request's data and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load-excl, 1 store-excl, 2 plain store, 3 clear |
| req_addr | input | ADDR_W | Physical byte address |
| req_shared | input | 1 | Shareable-memory attribute |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_wdata | input | 2*DATA_W | Store data, low word in low bits |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | ADDR_W | Address of the observed write |
| mem_we | output | 2 | Per-word write enables toward memory |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | 2*DATA_W | Forwarded write data |
| stx_status | output | 1 | Store-exclusive result, 1 = failed |

## Verification
The bench targets granule matching at its edge. An address a few bytes into the reserved granule must pass, and the adjacent granule must fail. A monitor that compares full addresses, or masks too many bits, gets one of these two wrong.

It places a snoop in the same cycle as a store-exclusive. A design that evaluates the store against the stale reservation would let a racing update through. It also sends snoops against a non-shared reservation, where clearing the flag by mistake turns a valid retry into a spurious failure.

Repeated store-exclusives and a doubleword failure check two further errors: a reservation that survives a failed attempt, and a doubleword that writes a single lane.

// File: rtl/exm_pkg.sv
package exm_pkg;

  typedef enum logic [1:0] {
    OP_LDX = 2'd0,
    OP_STX = 2'd1,
    OP_ST  = 2'd2,
    OP_CLR = 2'd3
  } exm_op_e;

  // per-word lane enables: bit0 low word, bit1 high word
  function automatic logic [1:0] lane_mask(input logic dword);
    return dword ? 2'b11 : 2'b01;
  endfunction

endpackage

// File: rtl/exm_resv_state.sv
module exm_resv_state #(
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             set_shared,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             drop_en,
  output logic             live,
  output logic             shared,
  output logic [TAG_W-1:0] tag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      shared <= 1'b0;
      tag    <= '0;
    end else if (set_en) begin
      live   <= 1'b1;
      shared <= set_shared;
      tag    <= set_tag;
    end else if (drop_en) begin
      live   <= 1'b0;
    end
  end

endmodule

// File: rtl/exm_snoop_filter.sv
module exm_snoop_filter #(
  parameter int TAG_W = 29
) (
  input  logic             snoop_valid,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic             live,
  input  logic             shared,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);

  // only an address-tagged reservation can be hit by another agent
  assign hit = snoop_valid && live && shared && (snoop_tag == tag);

endmodule

// File: rtl/exm_stx_judge.sv
module exm_stx_judge #(
  parameter int TAG_W = 29
) (
  input  logic             req_shared,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             live,
  input  logic             shared,
  input  logic [TAG_W-1:0] tag,
  output logic             pass
);

  always_comb begin
    if (!live)           pass = 1'b0;
    else if (req_shared) pass = shared && (req_tag == tag);
    else                 pass = 1'b1;
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import exm_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int GRANULE_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_shared,
  input  logic                req_dword,
  input  logic [2*DATA_W-1:0] req_wdata,
  input  logic                snoop_valid,
  input  logic [ADDR_W-1:0]   snoop_addr,
  output logic [1:0]          mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] mem_wdata,
  output logic                stx_status
);

  localparam int GRAN_LSB = $clog2(GRANULE_BYTES);
  localparam int TAG_W    = ADDR_W - GRAN_LSB;

  exm_op_e op;
  assign op = exm_op_e'(req_op);

  // named events, visible to the checker
  logic is_ldx, is_stx, is_st, is_clr;
  logic resv_live, resv_shared, live_eff, snoop_hit, stx_pass;
  logic [TAG_W-1:0] resv_tag, req_tag, snp_tag;

  assign is_ldx  = req_valid && (op == OP_LDX);
  assign is_stx  = req_valid && (op == OP_STX);
  assign is_st   = req_valid && (op == OP_ST);
  assign is_clr  = req_valid && (op == OP_CLR);
  assign req_tag = req_addr[ADDR_W-1:GRAN_LSB];
  assign snp_tag = snoop_addr[ADDR_W-1:GRAN_LSB];

  exm_resv_state #(.TAG_W(TAG_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (is_ldx),
    .set_shared (req_shared),
    .set_tag    (req_tag),
    .drop_en    (is_stx || is_clr || snoop_hit),
    .live       (resv_live),
    .shared     (resv_shared),
    .tag        (resv_tag)
  );

  exm_snoop_filter #(.TAG_W(TAG_W)) u_snoop (
    .snoop_valid (snoop_valid),
    .snoop_tag   (snp_tag),
    .live        (resv_live),
    .shared      (resv_shared),
    .tag         (resv_tag),
    .hit         (snoop_hit)
  );

  // a snoop landing this cycle is ordered before the local store
  assign live_eff = resv_live && !snoop_hit;

  exm_stx_judge #(.TAG_W(TAG_W)) u_judge (
    .req_shared (req_shared),
    .req_tag    (req_tag),
    .live       (live_eff),
    .shared     (resv_shared),
    .tag        (resv_tag),
    .pass       (stx_pass)
  );

  assign mem_we     = (is_st || (is_stx && stx_pass)) ? lane_mask(req_dword) : 2'b00;
  assign stx_status = is_stx && !stx_pass;
  assign mem_addr   = req_addr;
  assign mem_wdata  = req_wdata;

endmodule

// File: rtl/exm_chk.sv
module exm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       req_dword,
  input logic [1:0] mem_we,
  input logic       stx_status,
  input logic       resv_live,
  input logic       snoop_hit
);

  // R6
  stx_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) |=> !resv_live);

  // R2
  ldx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |=> resv_live);

  // R9
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> !resv_live);

  // R4
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stx_status |-> (req_valid && req_op == 2'd1 && mem_we == 2'b00));

  // R7
  dword_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dword && mem_we != 2'b00) |-> (mem_we == 2'b11));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op == 2'd0) |-> (mem_we == 2'b00 && !stx_status));

  // R8
  snoop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !(req_valid && req_op == 2'd0)) |=> !resv_live);

endmodule

bind excl_monitor exm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_dword  (req_dword),
  .mem_we     (mem_we),
  .stx_status (stx_status),
  .resv_live  (resv_live),
  .snoop_hit  (snoop_hit)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic        req_shared = 1'b0;
  logic        req_dword = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic [1:0]  mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        stx_status;

  always #2.5 clk = ~clk;

  excl_monitor u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_shared(req_shared), .req_dword(req_dword),
    .req_wdata(req_wdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stx_status(stx_status)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference: a reservation is "held", "kind" and a base address
  bit      m_held = 0;
  bit      m_kind = 0;
  int unsigned m_base = 0;

  function automatic int unsigned base_of(input logic [31:0] a);
    return a - (a % 8);
  endfunction

  task automatic check(input string req, input logic [1:0] we_exp, input logic st_exp);
    total++;
    if (mem_we !== we_exp || stx_status !== st_exp) begin
      bad++;
      $display("FAIL %s: mem_we=%b status=%b expected mem_we=%b status=%b",
               req, mem_we, stx_status, we_exp, st_exp);
    end
    if (we_exp != 2'b00) begin
      total++;
      if (mem_wdata !== req_wdata || mem_addr !== req_addr) begin
        bad++;
        $display("FAIL R11: data=%h addr=%h expected data=%h addr=%h",
                 mem_wdata, mem_addr, req_wdata, req_addr);
      end
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a,
                      input bit sh, input bit dw, input bit snv,
                      input logic [31:0] sna, input string req);
    logic [1:0] we_e;
    bit st_e, kill, ok;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_shared = sh; req_dword = dw;
    req_wdata = {$urandom, $urandom}; snoop_valid = snv; snoop_addr = sna;
    #1;
    kill = snv && m_held && m_kind && (base_of(sna) == m_base);
    we_e = 2'b00; st_e = 0;
    if (v) begin
      if (op == 2'd1) begin
        ok = m_held && !kill && (!sh || (m_kind && base_of(a) == m_base));
        if (ok) we_e = dw ? 2'b11 : 2'b01;
        else st_e = 1;
      end else if (op == 2'd2) begin
        we_e = dw ? 2'b11 : 2'b01;
      end
    end
    check(req, we_e, st_e);
    @(posedge clk);
    if (v && op == 2'd0) begin
      m_held = 1; m_kind = sh; m_base = base_of(a);
    end else if ((v && (op == 2'd1 || op == 2'd3)) || kill) begin
      m_held = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", 2'b00, 1'b0);
    rst_n = 1'b1;
    step(1, 2'd1, 32'h100, 1, 0, 0, 0, "R1");
    step(1, 2'd1, 32'h100, 0, 0, 0, 0, "R1");
    // R2 / R5 granule match, R6 clear on store
    step(1, 2'd0, 32'h100, 1, 0, 0, 0, "R11");
    step(1, 2'd1, 32'h104, 1, 0, 0, 0, "R5");
    step(1, 2'd1, 32'h104, 1, 0, 0, 0, "R6");
    step(1, 2'd0, 32'h100, 1, 0, 0, 0, "R2");
    step(1, 2'd0, 32'h200, 1, 0, 0, 0, "R2");
    step(1, 2'd1, 32'h100, 1, 0, 0, 0, "R2");
    step(1, 2'd0, 32'h200, 1, 0, 0, 0, "R5");
    step(1, 2'd1, 32'h208, 1, 0, 0, 0, "R5");
    // R3 / R4 non-shared
    step(1, 2'd0, 32'h300, 0, 0, 0, 0, "R3");
    step(1, 2'd1, 32'h900, 0, 0, 0, 0, "R3");
    step(1, 2'd1, 32'h900, 0, 0, 0, 0, "R4");
    // R7 doubleword
    step(1, 2'd0, 32'h400, 1, 1, 0, 0, "R7");
    step(1, 2'd1, 32'h400, 1, 1, 0, 0, "R7");
    step(1, 2'd1, 32'h400, 1, 1, 0, 0, "R7");
    // R8 snoops
    step(1, 2'd0, 32'h500, 1, 0, 0, 0, "R8");
    step(0, 2'd1, 32'h0,   0, 0, 1, 32'h600, "R8");
    step(1, 2'd1, 32'h500, 1, 0, 0, 0, "R8");
    step(1, 2'd0, 32'h500, 1, 0, 0, 0, "R8");
    step(0, 2'd0, 32'h0,   0, 0, 1, 32'h504, "R8");
    step(1, 2'd1, 32'h500, 1, 0, 0, 0, "R8");
    step(1, 2'd0, 32'h500, 1, 0, 0, 0, "R8");
    step(1, 2'd1, 32'h500, 1, 0, 1, 32'h500, "R8");
    step(1, 2'd0, 32'h700, 0, 0, 0, 0, "R8");
    step(0, 2'd0, 32'h0,   0, 0, 1, 32'h700, "R8");
    step(1, 2'd1, 32'h700, 0, 0, 0, 0, "R8");
    // R9 clear
    step(1, 2'd0, 32'h100, 1, 0, 0, 0, "R9");
    step(1, 2'd3, 32'h100, 0, 0, 0, 0, "R9");
    step(1, 2'd1, 32'h100, 1, 0, 0, 0, "R9");
    step(1, 2'd0, 32'h100, 0, 0, 0, 0, "R9");
    step(1, 2'd3, 32'h0,   0, 0, 0, 0, "R9");
    step(1, 2'd1, 32'h100, 0, 0, 0, 0, "R9");
    // R10 plain store leaves reservation
    step(1, 2'd0, 32'h800, 1, 0, 0, 0, "R10");
    step(1, 2'd2, 32'h800, 1, 1, 0, 0, "R10");
    step(1, 2'd2, 32'h900, 0, 0, 0, 0, "R10");
    step(1, 2'd1, 32'h800, 1, 0, 0, 0, "R10");
    // R11 idle with store-exclusive op pattern
    step(1, 2'd0, 32'h100, 1, 0, 0, 0, "R11");
    step(0, 2'd1, 32'h100, 1, 0, 0, 0, "R11");
    step(1, 2'd1, 32'h100, 1, 0, 0, 0, "R11");
    // mixed traffic over a few granules
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
           32'h100 + 32'($urandom_range(0, 5)) * 4, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0,
           32'h100 + 32'($urandom_range(0, 5)) * 4, "R5");
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule